// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Starvation Fallback

This block decides which of four bus masters owns a shared bus. Normally it picks the requesting master with the largest programmed 2-bit priority level. One port position is reserved: its request is discarded and it never receives the bus. Ownership moves only at a transfer boundary, when the current owner reports no outstanding work. Until that happens the grant stays where it is.

A starvation guard can be switched on. Each usable master then has a counter of the cycles in which it asked for the bus and was refused. If any counter reaches a programmable limit, the arbiter stops using priority and serves requesters in rotation. Once every locked-out master has been served, it returns to priority order. While nobody requests, the grant parks either on the highest-priority master or on the master that most recently won. The DMA master can also flag urgency, and when this is enabled that flag lifts it above every programmed level.

Top module: `prio_lockout_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no requests, the grant is 4'b0001 (master 0).
- R2: The grant is one-hot and registered. When busy_i is 1 at a clock edge the grant keeps its value. When busy_i is 0, the arbitration result appears on gnt_o after that edge.
- R3: In priority mode the requesting master with the largest level wins, where master m's level is prio_i[2m+1:2m]. A tie goes to the lower-numbered master.
- R4: Port 1 is reserved. Its request has no effect on the outcome and gnt_o[1] is never 1.
- R5: With starve_en_i set, each usable master's counter increases by one on every edge where it requests and is not the current grant holder. The counter stops at lock_lim_i and is cleared while the master holds the grant. A master is locked out when lock_lim_i is nonzero and its counter is at or above lock_lim_i.
- R6: While any master is locked out, the winner is the first requesting usable master found by counting upward, with wrap, from the current grant holder, excluding the holder itself unless no other master requests.
- R7: Once no master is locked out, arbitration is by priority again (R3).
- R8: With no usable request and park_high_i = 1, the grant moves to the usable master with the largest level, ties to the lower index.
- R9: With no usable request and park_high_i = 0, the grant moves to the master that last won an arbitration with requests present (master 0 after reset).
- R10: When urg_en_i and urg_i are both 1 and master 2 requests in priority mode, master 2 wins regardless of the levels.
- R11: When urg_en_i is 0, urg_i has no effect on the grant.
- R12: With starve_en_i at 0, counters stay at zero and the arbiter never leaves priority mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Bus request per master |
| busy_i | input | 1 | Current owner still has transfers outstanding |
| prio_i | input | 8 | Priority level, 2 bits per master, master m at bits 2m+1:2m |
| park_high_i | input | 1 | 1: park on highest level, 0: park on last winner |
| starve_en_i | input | 1 | Enable denial counters and lockout fallback |
| lock_lim_i | input | 8 | Denied-cycle count that triggers lockout (0 disables) |
| urg_en_i | input | 1 | Allow DMA urgency elevation |
| urg_i | input | 1 | Urgency flag from master 2 |
| gnt_o | output | 4 | One-hot registered grant |

## Verification
Every arbitration decision is made from the inputs present at a clock edge and shows on gnt_o right after that edge, so a decision is due one cycle after the stimulus. Denial counters change on that same edge, and a lockout therefore affects the decision on the edge after the counter reaches the limit. The bench drives inputs on the falling edge and runs a behavioural model on the rising edge. It compares gnt_o with the model at the next falling edge, so each result is sampled exactly one register stage after the stimulus that caused it.

// File: rtl/arb_pkg.sv
package arb_pkg;
    // level headroom bit added on top of the programmed priority for urgency
    localparam int ARB_URG_BITS = 1;

    function automatic int arb_level_w(input int prio_w);
        return prio_w + ARB_URG_BITS;
    endfunction
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
    parameter int N  = 4,
    parameter int EW = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]    valid_i,
    input  logic [N*EW-1:0] level_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        logic          hit;
        logic [EW-1:0] best;
        logic [IW-1:0] sel;
        hit  = 1'b0;
        best = '0;
        sel  = '0;
        for (int i = 0; i < N; i++) begin
            if (valid_i[i] && (!hit || level_i[i*EW +: EW] > best)) begin
                hit  = 1'b1;
                best = level_i[i*EW +: EW];
                sel  = IW'(i);
            end
        end
        found_o = hit;
        idx_o   = sel;
    end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  valid_i,
    input  logic [IW-1:0] ptr_i,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        logic          hit;
        logic [IW-1:0] sel;
        int            cand;
        hit = 1'b0;
        sel = ptr_i;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(ptr_i) + k) % N;
            if (!hit && valid_i[cand]) begin
                hit = 1'b1;
                sel = IW'(cand);
            end
        end
        idx_o = sel;
    end
endmodule

// File: rtl/arb_starve_ctr.sv
module arb_starve_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          req_i,
    input  logic          owner_i,
    input  logic [CW-1:0] lim_i,
    output logic          lock_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || owner_i)
            cnt_d = '0;
        else if (req_i && cnt_q < lim_i)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign lock_o = en_i && (lim_i != '0) && (cnt_q >= lim_i);
endmodule

// File: rtl/prio_lockout_arbiter.sv
module prio_lockout_arbiter #(
    parameter int NUM_M     = 4,
    parameter int PRIO_W    = 2,
    parameter int CNT_W     = 8,
    parameter int RSVD_PORT = 1,
    parameter int URG_PORT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_M-1:0]        req_i,
    input  logic                    busy_i,
    input  logic [NUM_M*PRIO_W-1:0] prio_i,
    input  logic                    park_high_i,
    input  logic                    starve_en_i,
    input  logic [CNT_W-1:0]        lock_lim_i,
    input  logic                    urg_en_i,
    input  logic                    urg_i,
    output logic [NUM_M-1:0]        gnt_o
);
    localparam int IDX_W = (NUM_M > 1) ? $clog2(NUM_M) : 1;
    localparam int LVL_W = arb_pkg::arb_level_w(PRIO_W);
    localparam logic [NUM_M-1:0] RSVD_BIT = NUM_M'(1) << RSVD_PORT;
    localparam logic [NUM_M-1:0] USABLE   = ~RSVD_BIT;

    typedef struct packed {
        logic [NUM_M-1:0] gnt;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_M-1:0]       eff_req;
    logic [NUM_M-1:0]       lock;
    logic [NUM_M*LVL_W-1:0] run_lvl;
    logic [NUM_M*LVL_W-1:0] park_lvl;
    logic                   fx_found, pk_found;
    logic [IDX_W-1:0]       fx_idx, pk_idx, rr_idx;

    assign eff_req = req_i & USABLE;

    // per-master levels: urgency bit on top of the programmed value
    generate
        for (genvar m = 0; m < NUM_M; m++) begin : g_lvl
            if (m == URG_PORT) begin : g_urg
                assign run_lvl[m*LVL_W +: LVL_W] = {urg_en_i & urg_i, prio_i[m*PRIO_W +: PRIO_W]};
            end else begin : g_plain
                assign run_lvl[m*LVL_W +: LVL_W] = {1'b0, prio_i[m*PRIO_W +: PRIO_W]};
            end
            assign park_lvl[m*LVL_W +: LVL_W] = {1'b0, prio_i[m*PRIO_W +: PRIO_W]};

            if (m == RSVD_PORT) begin : g_no_ctr
                assign lock[m] = 1'b0;
            end else begin : g_ctr
                arb_starve_ctr #(.CW(CNT_W)) u_ctr (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .en_i    (starve_en_i),
                    .req_i   (eff_req[m]),
                    .owner_i (st_q.gnt[m]),
                    .lim_i   (lock_lim_i),
                    .lock_o  (lock[m])
                );
            end
        end
    endgenerate

    arb_fixed_pick #(.N(NUM_M), .EW(LVL_W), .IW(IDX_W)) u_fixed (
        .valid_i (eff_req),
        .level_i (run_lvl),
        .found_o (fx_found),
        .idx_o   (fx_idx)
    );

    arb_fixed_pick #(.N(NUM_M), .EW(LVL_W), .IW(IDX_W)) u_park (
        .valid_i (USABLE),
        .level_i (park_lvl),
        .found_o (pk_found),
        .idx_o   (pk_idx)
    );

    arb_rr_pick #(.N(NUM_M), .IW(IDX_W)) u_rr (
        .valid_i (eff_req),
        .ptr_i   (st_q.owner),
        .idx_o   (rr_idx)
    );

    always_comb begin
        logic [IDX_W-1:0] win;
        st_d = st_q;
        win  = st_q.owner;
        if (!busy_i) begin
            if (fx_found) begin
                win       = (|lock) ? rr_idx : fx_idx;
                st_d.last = win;
            end else if (park_high_i && pk_found) begin
                win = pk_idx;
            end else begin
                win = st_q.last;
            end
            st_d.owner = win;
            st_d.gnt   = NUM_M'(1) << win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gnt   <= NUM_M'(1);
            st_q.owner <= '0;
            st_q.last  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = st_q.gnt;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int NUM_M     = 4,
    parameter int RSVD_PORT = 1,
    parameter int URG_PORT  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_M-1:0] req_i,
    input logic             busy_i,
    input logic             starve_en_i,
    input logic             urg_en_i,
    input logic             urg_i,
    input logic [NUM_M-1:0] gnt_o
);
    localparam logic [NUM_M-1:0] USABLE = ~(NUM_M'(1) << RSVD_PORT);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_o) == 1);

    p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(gnt_o));

    p_rsvd_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_o[RSVD_PORT]);

    p_winner_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && |(req_i & USABLE)) |=> |(gnt_o & $past(req_i) & USABLE));

    p_urgent_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !starve_en_i && urg_en_i && urg_i && req_i[URG_PORT]) |=> gnt_o[URG_PORT]);
endmodule

bind prio_lockout_arbiter arb_checker #(
    .NUM_M(NUM_M), .RSVD_PORT(RSVD_PORT), .URG_PORT(URG_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_i(busy_i),
    .starve_en_i(starve_en_i), .urg_en_i(urg_en_i), .urg_i(urg_i), .gnt_o(gnt_o)
);

// File: tb/sim_prio_lockout_arbiter.sv
`timescale 1ns/1ps
module sim_prio_lockout_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       busy = 1'b0;
    logic [7:0] prio = '0;
    logic       park_high = 1'b0;
    logic       starve_en = 1'b0;
    logic [7:0] lim = '0;
    logic       urg_en = 1'b0;
    logic       urg = 1'b0;
    logic [3:0] gnt;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int m_owner = 0;
    int m_last  = 0;
    int m_cnt [4];

    always #5 clk = ~clk;

    prio_lockout_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .prio_i(prio),
        .park_high_i(park_high), .starve_en_i(starve_en), .lock_lim_i(lim),
        .urg_en_i(urg_en), .urg_i(urg), .gnt_o(gnt)
    );

    function automatic int lvl(input int m, input bit with_urg);
        int v;
        v = int'(prio[m*2 +: 2]);
        if (with_urg && m == 2 && urg_en && urg) v += 4;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_owner = 0; m_last = 0;
            for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        end else begin
            bit any_lock;
            bit any_req;
            int win, best;
            any_lock = 0; any_req = 0;
            for (int i = 0; i < 4; i++) begin
                if (i != 1 && starve_en && lim != 0 && m_cnt[i] >= int'(lim)) any_lock = 1;
                if (i != 1 && req[i]) any_req = 1;
            end
            win = m_owner;
            if (!busy) begin
                if (any_req) begin
                    if (any_lock) begin
                        win = -1;
                        for (int k = 1; k <= 4; k++) begin
                            int c;
                            c = (m_owner + k) % 4;
                            if (win < 0 && c != 1 && req[c]) win = c;
                        end
                    end else begin
                        win = -1; best = -1;
                        for (int i = 0; i < 4; i++)
                            if (i != 1 && req[i] && lvl(i, 1) > best) begin
                                best = lvl(i, 1); win = i;
                            end
                    end
                    m_last = win;
                end else if (park_high) begin
                    win = -1; best = -1;
                    for (int i = 0; i < 4; i++)
                        if (i != 1 && lvl(i, 0) > best) begin
                            best = lvl(i, 0); win = i;
                        end
                end else begin
                    win = m_last;
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (i == 1 || !starve_en || i == m_owner) m_cnt[i] = 0;
                else if (req[i] && m_cnt[i] < int'(lim)) m_cnt[i] = m_cnt[i] + 1;
            end
            m_owner = win;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            n_chk++;
            if (gnt !== 4'(1 << m_owner)) begin
                n_fail++;
                $display("FAIL %s: gnt actual %b expected %b at %0t", tag, gnt, 4'(1 << m_owner), $time);
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    initial begin
        cycles(3);
        // R1 reset value seen while reset is held
        n_chk++;
        if (gnt !== 4'b0001) begin
            n_fail++;
            $display("FAIL R1: reset gnt actual %b expected %b", gnt, 4'b0001);
        end
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tag = "R1"; cycles(3);

        // R3 priority order and ties
        tag = "R3";
        prio = {2'd1, 2'd2, 2'd3, 2'd0};
        req = 4'b1101; cycles(3);
        req = 4'b1001; cycles(3);
        req = 4'b0011; cycles(3);
        prio = 8'h00; req = 4'b1100; cycles(3);
        prio = 8'hFF; req = 4'b1101; cycles(3);

        // R4 reserved port request alone
        tag = "R4";
        req = 4'b0010; cycles(4);
        req = 4'b1010; prio = {2'd0, 2'd0, 2'd3, 2'd0}; cycles(3);

        // R2 hold while busy
        tag = "R2";
        req = 4'b0001; cycles(2);
        busy = 1'b1;
        req = 4'b1100; cycles(2);
        req = 4'b1000; cycles(2);
        busy = 1'b0; cycles(2);

        // R8 park on highest level
        tag = "R8";
        prio = {2'd3, 2'd0, 2'd0, 2'd1};
        park_high = 1'b1; req = 4'b0000; cycles(3);
        prio = {2'd1, 2'd2, 2'd0, 2'd2}; cycles(3);

        // R9 park on last winner
        tag = "R9";
        park_high = 1'b0;
        req = 4'b0100; cycles(2);
        req = 4'b0000; cycles(3);
        req = 4'b1000; cycles(1);
        req = 4'b0000; cycles(3);

        // R10 urgency lift
        tag = "R10";
        prio = {2'd3, 2'd0, 2'd0, 2'd2};
        urg_en = 1'b1; urg = 1'b1; req = 4'b1101; cycles(3);
        // R11 urgency ignored without enable
        tag = "R11";
        urg_en = 1'b0; cycles(3);
        urg_en = 1'b1; urg = 1'b0; cycles(3);
        urg_en = 1'b0;

        // R12 no fallback when the guard is off
        tag = "R12";
        prio = {2'd0, 2'd0, 2'd0, 2'd3};
        lim = 8'd2; req = 4'b1101; cycles(20);

        // R5 R6 lockout and rotation
        tag = "R5 R6";
        starve_en = 1'b1; lim = 8'd3; cycles(30);
        // R7 back to priority once lockouts are gone
        tag = "R7";
        lim = 8'd60; cycles(10);

        // mixed traffic against the model
        tag = "R2 R3 R5 R6 R8 R9 R10";
        for (int i = 0; i < 4000; i++) begin
            req  = 4'($urandom_range(0, 15));
            busy = ($urandom_range(0, 9) < 3);
            urg  = $urandom_range(0, 1) == 1;
            if (i % 97 == 0) begin
                prio = 8'($urandom_range(0, 255));
                park_high = $urandom_range(0, 1) == 1;
                urg_en = $urandom_range(0, 1) == 1;
                starve_en = $urandom_range(0, 3) != 0;
                lim = 8'($urandom_range(0, 6));
            end
            cycles(1);
        end
        finish_up();
    end
endmodule